// File: doc/BRIEF.md
# Pipelined Shared-Bus Arbiter with Slave Select

This block lets several masters share one bus that reaches several slave targets. A master raises its request line and waits. The arbiter registers a one-hot grant. A granted master with its request high drives an address phase. That phase is accepted on a clock edge where the bus is ready. The data phase of that transfer runs in the next cycle. In that same cycle the next address phase, from the same master or a different one, can already be accepted, so transfers overlap by one stage.

The region field of the address (its top `REGION_W` bits) picks the slave. A slave pulls its ready line low to stretch its data phase. While it is low, the bus-ready output is low, and the grant, the priority pointer and the data-phase registers all keep their values. Addresses that fall in no slave region complete in a single data cycle and return zeros. Write data and the data-phase write enable come from the master that owned the address phase, which is not necessarily the master granted at that time.

The data-phase sequencer has three states. DP_IDLE means no data phase is in progress. DP_SLAVE means a mapped slave is serving the data phase. DP_UNMAPPED means a one-cycle data phase for an address that hits no slave. The transitions are:
- Accepting an address that hits a slave leads to DP_SLAVE.
- Accepting an address that hits no slave leads to DP_UNMAPPED.
- A ready cycle with no accept leads to DP_IDLE.
- A stalled cycle (DP_SLAVE with the slave's ready low) stays in DP_SLAVE.

Top module: `pipe_bus_fabric`

## Requirements
- R1: After reset, no grant is asserted, bus ready is high, no slave select is asserted and no data-phase owner is flagged.
- R2: The grant is one-hot or zero and is registered. An uncontended request on an idle bus is granted on the first clock edge after it is raised. No grant follows a ready edge where no request is high.
- R3: Priority is round-robin. After master k has an address phase accepted, the search for the next grant starts at master k+1, modulo the master count. After reset the search starts at master 0.
- R4: An address phase is accepted on an edge where the granted master's request and bus ready are both high. `s_sel[i]` is high when the granted master requests and address bits [AW-1 -: REGION_W] equal i, for i < N_SLV. `s_addr` carries the granted master's address.
- R5: The next address phase can be accepted on the edge that completes the previous transfer's address phase plus one. Consecutive transfers from different masters are accepted on consecutive edges while their data phases overlap.
- R6: While the data-phase slave holds its ready low, `m_ready` is low, and the grant and the data-phase state do not change. A data phase to a slave that inserts W wait cycles lasts W+1 cycles.
- R7: An address that hits no slave region completes in exactly one data cycle, with `m_rdata` all zeros and `s_dwe` low.
- R8: During a write data phase, `s_wdata` is the write data of the master that owned the preceding address phase, and `s_dwe` is high.
- R9: During a read data phase, `m_rdata` is the read data of the slave that was selected in the preceding address phase.
- R10: `m_downer` is one-hot while a data phase is in progress, flags the master that owns it, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | N_MST | Request per master |
| m_addr | input | N_MST*AW | Address per master, master i at [i*AW +: AW] |
| m_write | input | N_MST | Address-phase write flag per master |
| m_wdata | input | N_MST*DW | Data-phase write data per master |
| m_gnt | output | N_MST | One-hot registered grant |
| m_ready | output | 1 | Bus ready; low while a data phase is stretched |
| m_rdata | output | DW | Read data of the current data phase |
| m_downer | output | N_MST | One-hot owner of the current data phase |
| s_sel | output | N_SLV | Address-phase slave select |
| s_addr | output | AW | Address-phase address |
| s_write | output | 1 | Address-phase write flag |
| s_wdata | output | DW | Data-phase write data |
| s_dwe | output | 1 | Data-phase write enable |
| s_rdata | input | N_SLV*DW | Read data per slave, slave i at [i*DW +: DW] |
| s_ready | input | N_SLV | Ready per slave for its data phase |

## Verification
The first pattern is a lone master on an idle bus. It separates grant latency from arbitration effects. The second pattern has all masters requesting at once, starting from two different priority pointers. This tells true round-robin rotation apart from fixed priority, and it shows whether address phases are accepted on back-to-back edges while the data phases overlap. A slave that inserts wait cycles while another master waits shows whether the grant and the pipeline freeze for exactly the stretch. Writes issued while a different master holds the grant tell the data-owner mux apart from a grant-based mux, and an unmapped address tells the one-cycle zero response apart from a real slave access.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

    // Data-phase sequencer states
    typedef enum logic [1:0] {
        DP_IDLE     = 2'd0,
        DP_SLAVE    = 2'd1,
        DP_UNMAPPED = 2'd2
    } dphase_e;

endpackage

// File: rtl/pbf_rr_arbiter.sv
module pbf_rr_arbiter #(
    parameter int N_MST = 3,
    localparam int IDXW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    input  logic             hready,
    output logic [N_MST-1:0] gnt,
    output logic [IDXW-1:0]  a_owner,
    output logic             a_valid,
    output logic             accept
);

    logic [N_MST-1:0] gnt_q;
    logic [N_MST-1:0] gnt_nxt;
    logic [IDXW-1:0]  ptr_q;
    logic [IDXW-1:0]  ptr_nxt;

    // Current owner, accept and next grant search
    always_comb begin
        int  idx;
        logic found;
        a_owner = '0;
        for (int i = 0; i < N_MST; i++) begin
            if (gnt_q[i]) a_owner = IDXW'(i);
        end
        a_valid = |(gnt_q & req);
        accept  = a_valid && hready;
        if (accept) begin
            ptr_nxt = (a_owner == IDXW'(N_MST - 1)) ? '0 : a_owner + IDXW'(1);
        end else begin
            ptr_nxt = ptr_q;
        end
        gnt_nxt = '0;
        found   = 1'b0;
        for (int k = 0; k < N_MST; k++) begin
            idx = (int'(ptr_nxt) + k) % N_MST;
            if (!found && req[idx]) begin
                gnt_nxt[idx] = 1'b1;
                found        = 1'b1;
            end
        end
    end

    // Grant and pointer registers, frozen during a stall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= '0;
            ptr_q <= '0;
        end else if (hready) begin
            gnt_q <= gnt_nxt;
            ptr_q <= ptr_nxt;
        end
    end

    assign gnt = gnt_q;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_q)); // R2

    AST_NO_REQ_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && (req == '0)) |=> (gnt_q == '0)); // R2

    AST_GNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(gnt_q)); // R6

endmodule

// File: rtl/pbf_addr_decode.sv
module pbf_addr_decode #(
    parameter int AW       = 16,
    parameter int N_SLV    = 4,
    parameter int REGION_W = 4,
    localparam int SIDXW   = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
    input  logic [AW-1:0]    addr,
    input  logic             valid,
    output logic [N_SLV-1:0] sel,
    output logic             hit,
    output logic [SIDXW-1:0] sidx
);

    logic [REGION_W-1:0] region;
    assign region = addr[AW-1 -: REGION_W];

    for (genvar i = 0; i < N_SLV; i++) begin : g_region
        assign sel[i] = valid && (region == REGION_W'(i));
    end

    assign hit = |sel;

    always_comb begin
        sidx = '0;
        for (int i = 0; i < N_SLV; i++) begin
            if (sel[i]) sidx = SIDXW'(i);
        end
    end

endmodule

// File: rtl/pbf_dphase_fsm.sv
module pbf_dphase_fsm
    import pbf_pkg::*;
#(
    parameter int N_MST  = 3,
    parameter int N_SLV  = 4,
    localparam int IDXW  = (N_MST > 1) ? $clog2(N_MST) : 1,
    localparam int SIDXW = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             hit,
    input  logic [IDXW-1:0]  a_owner,
    input  logic [SIDXW-1:0] a_sidx,
    input  logic             a_write,
    input  logic [N_SLV-1:0] slv_ready,
    output dphase_e          state,
    output logic [IDXW-1:0]  d_owner,
    output logic [SIDXW-1:0] d_sidx,
    output logic             d_write,
    output logic             hready
);

    dphase_e          state_q;
    dphase_e          state_nxt;
    logic [IDXW-1:0]  owner_q;
    logic [SIDXW-1:0] sidx_q;
    logic             write_q;

    // Next-state selection
    always_comb begin
        state_nxt = state_q;
        if (hready) begin
            if (accept && hit)       state_nxt = DP_SLAVE;
            else if (accept && !hit) state_nxt = DP_UNMAPPED;
            else                     state_nxt = DP_IDLE;
        end
    end

    // State register with data-phase context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DP_IDLE;
            owner_q <= '0;
            sidx_q  <= '0;
            write_q <= 1'b0;
        end else if (hready) begin
            state_q <= state_nxt;
            owner_q <= a_owner;
            sidx_q  <= a_sidx;
            write_q <= a_write;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            DP_IDLE:     hready = 1'b1;
            DP_SLAVE:    hready = slv_ready[sidx_q];
            DP_UNMAPPED: hready = 1'b1;
            default:     hready = 1'b1;
        endcase
    end

    assign state   = state_q;
    assign d_owner = owner_q;
    assign d_sidx  = sidx_q;
    assign d_write = write_q;

    AST_DP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> ($stable(state_q) && $stable(owner_q) && $stable(sidx_q))); // R6

    AST_ACCEPT_STARTS_DP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state_q != DP_IDLE)); // R5

    AST_UNMAPPED_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DP_UNMAPPED && !accept) |=> (state_q == DP_IDLE)); // R7

endmodule

// File: rtl/pipe_bus_fabric.sv
module pipe_bus_fabric
    import pbf_pkg::*;
#(
    parameter int N_MST    = 3,
    parameter int N_SLV    = 4,
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int REGION_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_MST-1:0]   m_req,
    input  logic [N_MST*AW-1:0] m_addr,
    input  logic [N_MST-1:0]   m_write,
    input  logic [N_MST*DW-1:0] m_wdata,
    output logic [N_MST-1:0]   m_gnt,
    output logic               m_ready,
    output logic [DW-1:0]      m_rdata,
    output logic [N_MST-1:0]   m_downer,
    output logic [N_SLV-1:0]   s_sel,
    output logic [AW-1:0]      s_addr,
    output logic               s_write,
    output logic [DW-1:0]      s_wdata,
    output logic               s_dwe,
    input  logic [N_SLV*DW-1:0] s_rdata,
    input  logic [N_SLV-1:0]   s_ready
);

    localparam int IDXW  = (N_MST > 1) ? $clog2(N_MST) : 1;
    localparam int SIDXW = (N_SLV > 1) ? $clog2(N_SLV) : 1;

    logic [AW-1:0] addr_arr  [N_MST];
    logic [DW-1:0] wdata_arr [N_MST];
    logic [DW-1:0] rdata_arr [N_SLV];

    for (genvar i = 0; i < N_MST; i++) begin : g_mst
        assign addr_arr[i]  = m_addr[i*AW +: AW];
        assign wdata_arr[i] = m_wdata[i*DW +: DW];
    end

    for (genvar j = 0; j < N_SLV; j++) begin : g_slv
        assign rdata_arr[j] = s_rdata[j*DW +: DW];
    end

    logic             hready;
    logic [IDXW-1:0]  a_owner;
    logic             a_valid;
    logic             accept;
    logic             hit;
    logic [SIDXW-1:0] a_sidx;
    dphase_e          state;
    logic [IDXW-1:0]  d_owner;
    logic [SIDXW-1:0] d_sidx;
    logic             d_write;
    logic [AW-1:0]    a_addr;
    logic             a_write;

    pbf_rr_arbiter #(.N_MST(N_MST)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (m_req),
        .hready  (hready),
        .gnt     (m_gnt),
        .a_owner (a_owner),
        .a_valid (a_valid),
        .accept  (accept)
    );

    // Address-phase mux from the granted master
    assign a_addr  = addr_arr[a_owner];
    assign a_write = m_write[a_owner];

    pbf_addr_decode #(.AW(AW), .N_SLV(N_SLV), .REGION_W(REGION_W)) u_dec (
        .addr  (a_addr),
        .valid (a_valid),
        .sel   (s_sel),
        .hit   (hit),
        .sidx  (a_sidx)
    );

    pbf_dphase_fsm #(.N_MST(N_MST), .N_SLV(N_SLV)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .hit       (hit),
        .a_owner   (a_owner),
        .a_sidx    (a_sidx),
        .a_write   (a_write),
        .slv_ready (s_ready),
        .state     (state),
        .d_owner   (d_owner),
        .d_sidx    (d_sidx),
        .d_write   (d_write),
        .hready    (hready)
    );

    assign s_addr  = a_addr;
    assign s_write = a_write;
    assign m_ready = hready;

    // Data-phase muxes follow the data-phase owner, not the grant
    assign s_wdata = wdata_arr[d_owner];
    assign s_dwe   = (state == DP_SLAVE) && d_write;
    assign m_rdata = (state == DP_SLAVE) ? rdata_arr[d_sidx] : '0;

    for (genvar i = 0; i < N_MST; i++) begin : g_down
        assign m_downer[i] = (state != DP_IDLE) && (d_owner == IDXW'(i));
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_sel)); // R4

    AST_DOWNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_downer)); // R10

    AST_SEL_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_sel != '0) |-> ((m_gnt & m_req) != '0)); // R4

endmodule

// File: tb/pipe_bus_fabric_tb.sv
module pipe_bus_fabric_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NM = 3;
    localparam int NS = 4;
    localparam int AW = 16;
    localparam int DW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NM-1:0]     m_req = '0;
    logic [NM*AW-1:0]  m_addr = '0;
    logic [NM-1:0]     m_write = '0;
    logic [NM*DW-1:0]  m_wdata = '0;
    logic [NM-1:0]     m_gnt;
    logic              m_ready;
    logic [DW-1:0]     m_rdata;
    logic [NM-1:0]     m_downer;
    logic [NS-1:0]     s_sel;
    logic [AW-1:0]     s_addr;
    logic              s_write;
    logic [DW-1:0]     s_wdata;
    logic              s_dwe;
    logic [NS*DW-1:0]  s_rdata;
    logic [NS-1:0]     s_ready;

    pipe_bus_fabric #(.N_MST(NM), .N_SLV(NS), .AW(AW), .DW(DW), .REGION_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr), .m_write(m_write),
        .m_wdata(m_wdata), .m_gnt(m_gnt), .m_ready(m_ready), .m_rdata(m_rdata),
        .m_downer(m_downer), .s_sel(s_sel), .s_addr(s_addr), .s_write(s_write),
        .s_wdata(s_wdata), .s_dwe(s_dwe), .s_rdata(s_rdata), .s_ready(s_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int waitcfg [NS];
    int acc_m   [$];
    int acc_cyc [$];

    typedef struct {
        int          m;
        bit          wr;
        bit          mapped;
        logic [15:0] wd;
        logic [15:0] rexp;
    } item_t;
    item_t sb [$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] resp(int i, logic [15:0] a);
        logic [31:0] k;
        k = 32'h1357 * (i + 1);
        return a ^ k[15:0];
    endfunction

    function automatic logic [15:0] junk(int m);
        return 16'hDEA0 + 16'(m);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Slave models with programmable wait cycles
    logic [15:0] lat [NS];
    int          cnt [NS];
    for (genvar i = 0; i < NS; i++) begin : g_smodel
        always @(posedge clk) begin
            if (!rst_n) begin
                cnt[i] <= 0;
                lat[i] <= '0;
            end else if (m_ready && s_sel[i]) begin
                lat[i] <= s_addr;
                cnt[i] <= waitcfg[i];
            end else if (cnt[i] != 0) begin
                cnt[i] <= cnt[i] - 1;
            end
        end
        assign s_ready[i] = (cnt[i] == 0);
        assign s_rdata[i*DW +: DW] = resp(i, lat[i]);
    end

    // Master driver: pushes the expected data-phase item at acceptance
    task automatic xfer(int m, logic [15:0] a, bit wr, logic [15:0] wd, output int gwait);
        item_t it;
        int sidx, dexp, d;
        sidx = int'(a[15:12]);
        it.m = m; it.wr = wr; it.wd = wd;
        it.mapped = (sidx < NS);
        it.rexp = (!wr && it.mapped) ? resp(sidx, a) : 16'h0000;
        @(negedge clk);
        m_req[m] = 1'b1;
        m_addr[m*AW +: AW] = a;
        m_write[m] = wr;
        gwait = 0;
        forever begin
            @(negedge clk);
            gwait++;
            if (m_gnt[m] && m_ready) break;
            if (gwait > 1000) break;
        end
        dexp = it.mapped ? waitcfg[sidx] + 1 : 1;
        sb.push_back(it);
        acc_m.push_back(m);
        acc_cyc.push_back(cyc);
        @(posedge clk);
        #1;
        m_req[m] = 1'b0;
        m_wdata[m*DW +: DW] = wd;
        d = 0;
        forever begin
            @(negedge clk);
            d++;
            if (m_downer[m] && m_ready) break;
            if (d > 1000) break;
        end
        if (it.mapped)
            check(d == dexp, "R6", "data phase length", d, dexp);
        else
            check(d == dexp, "R7", "unmapped data phase length", d, dexp);
        @(posedge clk);
        #1;
        m_wdata[m*DW +: DW] = junk(m);
    endtask

    // Monitor: pops the scoreboard at each completed data phase
    logic [NM-1:0] prev_gnt = '0;
    bit            prev_stall = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(m_gnt == prev_gnt, "R6", "grant held during stall", int'(m_gnt), int'(prev_gnt));
            if (m_ready && (m_downer != '0)) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected data phase", int'(m_downer), 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(m_downer == NM'(1 << it.m), "R10", "data owner", int'(m_downer), 1 << it.m);
                    if (!it.mapped) begin
                        check(m_rdata == 16'h0 && !s_dwe, "R7", "unmapped rdata/dwe", int'(m_rdata), 0);
                    end else if (it.wr) begin
                        check(s_dwe == 1'b1, "R8", "write enable", int'(s_dwe), 1);
                        check(s_wdata == it.wd, "R8", "write data from owner", int'(s_wdata), int'(it.wd));
                    end else begin
                        check(m_rdata == it.rexp, "R9", "read data", int'(m_rdata), int'(it.rexp));
                        check(s_dwe == 1'b0, "R9", "no write enable on read", int'(s_dwe), 0);
                    end
                end
            end
            prev_stall = !m_ready;
            prev_gnt   = m_gnt;
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int g0, g1, g2, base;
        for (int i = 0; i < NS; i++) waitcfg[i] = 0;
        for (int m = 0; m < NM; m++) m_wdata[m*DW +: DW] = junk(m);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(m_gnt == '0, "R1", "grant after reset", int'(m_gnt), 0);
        check(m_ready == 1'b1, "R1", "ready after reset", int'(m_ready), 1);
        check(s_sel == '0, "R1", "select after reset", int'(s_sel), 0);
        check(m_downer == '0, "R1", "owner after reset", int'(m_downer), 0);

        // R2 R9: lone read, grant after one edge
        xfer(0, 16'h1024, 1'b0, 16'h0, g0);
        check(g0 == 1, "R2", "uncontended grant latency", g0, 1);

        // R8 R4: lone write to slave 3
        xfer(2, 16'h3ABC, 1'b1, 16'hC0DE, g0);

        // R6: stretched read on slave 2 while master 0 waits
        waitcfg[2] = 3;
        acc_m.delete(); acc_cyc.delete();
        fork
            xfer(1, 16'h2200, 1'b0, 16'h0, g1);
            begin @(negedge clk); xfer(0, 16'h0040, 1'b1, 16'h5A5A, g0); end
        join
        check(acc_m.size() == 2 && acc_m[0] == 1 && acc_m[1] == 0, "R6", "order across stall", acc_m[0], 1);
        check(acc_cyc[1] - acc_cyc[0] == 4, "R6", "next accept after stretch", acc_cyc[1] - acc_cyc[0], 4);
        waitcfg[2] = 0;

        // R7: unmapped region
        xfer(2, 16'hA010, 1'b0, 16'h0, g2);

        // R3 R5: all masters at once from pointer 0
        acc_m.delete(); acc_cyc.delete();
        fork
            xfer(0, 16'h0100, 1'b1, 16'h1111, g0);
            xfer(1, 16'h1200, 1'b0, 16'h0, g1);
            xfer(2, 16'h2300, 1'b1, 16'h3333, g2);
        join
        check(acc_m[0] == 0 && acc_m[1] == 1 && acc_m[2] == 2, "R3", "round-robin order from 0",
              acc_m[0]*100 + acc_m[1]*10 + acc_m[2], 12);
        base = acc_cyc[0];
        check(acc_cyc[1] == base + 1 && acc_cyc[2] == base + 2, "R5", "back-to-back accepts",
              acc_cyc[2] - base, 2);

        // R3: master 1 alone moves the pointer to 2
        xfer(1, 16'h3000, 1'b0, 16'h0, g1);
        acc_m.delete(); acc_cyc.delete();
        fork
            xfer(0, 16'h0500, 1'b0, 16'h0, g0);
            xfer(1, 16'h1600, 1'b1, 16'h7777, g1);
            xfer(2, 16'h3700, 1'b0, 16'h0, g2);
        join
        check(acc_m[0] == 2 && acc_m[1] == 0 && acc_m[2] == 1, "R3", "round-robin order from 2",
              acc_m[0]*100 + acc_m[1]*10 + acc_m[2], 201);

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);
        check(m_downer == '0 && m_gnt == '0, "R2", "idle after traffic", int'(m_gnt), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule